// File: doc/BRIEF.md
# ECAM Configuration Address Decoder

This block sits between a configuration access source and a memory-mapped configuration window. Each request carries a bus number, a device/function number and a register offset. The block turns these into a byte offset inside the window, and it decides whether the access may go out. A rejected read completes with all ones. A rejected write is dropped without effect.

Each request is filtered in priority order:
1. The window must be enabled.
2. The bus number must not exceed the last bus number. The last bus number is taken from a size field in the control register.
3. The route rule applies. On the root bus only device/function 0 answers. Any bus other than the root is reachable only while the link-up status is high.

A control register holds the enable bit and the size field. A read-only capability word reports that the window is present.

By default the result is registered, so it appears one cycle after the request. A parameter can select a purely combinational output instead.

Top module: `ecam_cfg_decode`

## Requirements
- R1: For an accepted request the offset equals (bus << 20) | (devfn << 12) + reg, with an 8-bit bus, an 8-bit devfn and a 12-bit reg, giving a 28-bit offset.
- R2: On the root bus a request with a nonzero devfn is rejected. A request with devfn 0 on the root bus is accepted whatever the link-up input is.
- R3: A request to a bus other than `root_bus` is rejected while `link_up` is 0 and accepted while it is 1, if the other rules pass.
- R4: The last bus number is the 5-bit size field. A request whose bus equals it is accepted, and one whose bus is greater is rejected.
- R5: While the enable bit is 0 every request is rejected, whatever its fields are.
- R6: The control register has the enable in bit 0 and the size in bits 20:16. All other bits read 0. It resets to 0x000C0000 (size 12, disabled), and a write takes effect on the next clock edge.
- R7: Bit 0 of the capability word reads 1 (window present). All other bits read 0.
- R8: A rejected read raises `out_fill_ones` and gives offset 0. A rejected write leaves `out_wr_go` low. An accepted write raises `out_wr_go`.
- R9: `out_valid` is high exactly one cycle after a cycle in which `req_valid` was high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 32 | Control register write value |
| ctl_rd_data | output | 32 | Control register read value |
| cap_rd_data | output | 32 | Capability word, bit 0 = present |
| root_bus | input | 8 | Bus number of the root |
| link_up | input | 1 | Link-up status |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Request bus number |
| req_devfn | input | 8 | Request device/function number |
| req_reg | input | 12 | Request register byte offset |
| out_valid | output | 1 | Result valid |
| out_accept | output | 1 | Request passed all rules |
| out_offset | output | 28 | Window byte offset, 0 when rejected |
| out_fill_ones | output | 1 | Rejected read, return all ones |
| out_wr_go | output | 1 | Accepted write may proceed |

## Verification
The offset is driven with bus, devfn and register values whose bits fall in separate fields. A swapped shift or a lost field therefore gives a distinct wrong value.

Each filter rule is isolated by changing one input at a time:
- devfn 0 against devfn 1 on the root bus;
- link down against link up on a non-root bus;
- bus equal to the last bus against one above it;
- enable set against clear.

This separates the rules from one another and shows their priority. Reads and writes are sent through both outcomes, so the fill-ones and write-drop signals are each seen against the accept flag.

// File: rtl/cfg_dec_pkg.sv
package cfg_dec_pkg;

   // Verdict of the request filter, listed in priority order
   typedef enum logic [1:0] {
      VD_PASS  = 2'd0,
      VD_OFF   = 2'd1,
      VD_RANGE = 2'd2,
      VD_ROUTE = 2'd3
   } verdict_e;

   localparam int CTL_EN_BIT = 0;

endpackage

// File: rtl/cfg_ctl_reg.sv
module cfg_ctl_reg #(
   parameter int CSR_W      = 32,
   parameter int SIZE_LSB   = 16,
   parameter int SIZE_W     = 5,
   parameter int SIZE_RESET = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CSR_W-1:0]  wr_data,
   output logic [CSR_W-1:0]  rd_data,
   output logic              en_o,
   output logic [SIZE_W-1:0] size_o
);
   import cfg_dec_pkg::*;

   localparam int SIZE_MSB = SIZE_LSB + SIZE_W - 1;

   if (SIZE_MSB >= CSR_W) begin : g_bad_size
      $error("size field does not fit in control word");
   end
   if (SIZE_LSB <= CTL_EN_BIT) begin : g_bad_lsb
      $error("size field overlaps enable bit");
   end

   logic              en_q;
   logic [SIZE_W-1:0] size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         size_q <= SIZE_W'(SIZE_RESET);
      end else if (wr_en) begin
         en_q   <= wr_data[CTL_EN_BIT];
         size_q <= wr_data[SIZE_MSB:SIZE_LSB];
      end
   end

   always_comb begin
      rd_data                    = '0;
      rd_data[CTL_EN_BIT]        = en_q;
      rd_data[SIZE_MSB:SIZE_LSB] = size_q;
   end

   assign en_o   = en_q;
   assign size_o = size_q;

   // R6: without a write strobe the stored fields hold
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(en_q) && $stable(size_q)));

endmodule

// File: rtl/cfg_req_filter.sv
module cfg_req_filter #(
   parameter int BUS_W   = 8,
   parameter int DEVFN_W = 8,
   parameter int SIZE_W  = 5
) (
   input  logic               en_i,
   input  logic [SIZE_W-1:0]  last_bus_i,
   input  logic [BUS_W-1:0]   root_bus_i,
   input  logic               link_up_i,
   input  logic [BUS_W-1:0]   bus_i,
   input  logic [DEVFN_W-1:0] devfn_i,
   output cfg_dec_pkg::verdict_e verdict_o
);
   import cfg_dec_pkg::*;

   if (SIZE_W > BUS_W) begin : g_bad_w
      $error("size field wider than bus number");
   end

   logic [BUS_W-1:0] last_bus_ext;
   logic             on_root;
   logic             route_ok;

   assign last_bus_ext = BUS_W'(last_bus_i);
   assign on_root      = (bus_i == root_bus_i);
   assign route_ok     = on_root ? (devfn_i == '0) : link_up_i;

   always_comb begin
      if (!en_i)                      verdict_o = VD_OFF;
      else if (bus_i > last_bus_ext)  verdict_o = VD_RANGE;
      else if (!route_ok)             verdict_o = VD_ROUTE;
      else                            verdict_o = VD_PASS;
   end

endmodule

// File: rtl/cfg_offset_gen.sv
module cfg_offset_gen #(
   parameter int BUS_W   = 8,
   parameter int DEVFN_W = 8,
   parameter int REG_W   = 12,
   parameter int OFF_W   = BUS_W + DEVFN_W + REG_W
) (
   input  logic [BUS_W-1:0]   bus_i,
   input  logic [DEVFN_W-1:0] devfn_i,
   input  logic [REG_W-1:0]   reg_i,
   output logic [OFF_W-1:0]   off_o
);
   localparam int DEVFN_SH = REG_W;
   localparam int BUS_SH   = REG_W + DEVFN_W;

   if (OFF_W < BUS_SH + BUS_W) begin : g_bad_off
      $error("offset too narrow for bus field");
   end

   logic [OFF_W-1:0] hi_part;

   assign hi_part = (OFF_W'(bus_i) << BUS_SH) | (OFF_W'(devfn_i) << DEVFN_SH);
   assign off_o   = hi_part + OFF_W'(reg_i);

endmodule

// File: rtl/ecam_cfg_decode.sv
module ecam_cfg_decode #(
   parameter int BUS_W       = 8,
   parameter int DEVFN_W     = 8,
   parameter int REG_W       = 12,
   parameter int CSR_W       = 32,
   parameter int SIZE_LSB    = 16,
   parameter int SIZE_W      = 5,
   parameter int SIZE_RESET  = 12,
   parameter bit PIPE_OUT    = 1'b1,
   parameter int OFF_W       = BUS_W + DEVFN_W + REG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctl_wr_en,
   input  logic [CSR_W-1:0]   ctl_wr_data,
   output logic [CSR_W-1:0]   ctl_rd_data,
   output logic [CSR_W-1:0]   cap_rd_data,
   input  logic [BUS_W-1:0]   root_bus,
   input  logic               link_up,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [BUS_W-1:0]   req_bus,
   input  logic [DEVFN_W-1:0] req_devfn,
   input  logic [REG_W-1:0]   req_reg,
   output logic               out_valid,
   output logic               out_accept,
   output logic [OFF_W-1:0]   out_offset,
   output logic               out_fill_ones,
   output logic               out_wr_go
);
   import cfg_dec_pkg::*;

   logic              en_w;
   logic [SIZE_W-1:0] size_w;
   verdict_e          verdict_w;
   logic [OFF_W-1:0]  off_w;

   logic              nx_accept;
   logic [OFF_W-1:0]  nx_offset;
   logic              nx_fill;
   logic              nx_wgo;

   cfg_ctl_reg #(
      .CSR_W(CSR_W), .SIZE_LSB(SIZE_LSB), .SIZE_W(SIZE_W), .SIZE_RESET(SIZE_RESET)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
      .rd_data(ctl_rd_data), .en_o(en_w), .size_o(size_w)
   );

   cfg_req_filter #(
      .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .SIZE_W(SIZE_W)
   ) u_flt (
      .en_i(en_w), .last_bus_i(size_w), .root_bus_i(root_bus), .link_up_i(link_up),
      .bus_i(req_bus), .devfn_i(req_devfn), .verdict_o(verdict_w)
   );

   cfg_offset_gen #(
      .BUS_W(BUS_W), .DEVFN_W(DEVFN_W), .REG_W(REG_W), .OFF_W(OFF_W)
   ) u_off (
      .bus_i(req_bus), .devfn_i(req_devfn), .reg_i(req_reg), .off_o(off_w)
   );

   always_comb begin
      cap_rd_data    = '0;
      cap_rd_data[0] = 1'b1;
   end

   assign nx_accept = req_valid && (verdict_w == VD_PASS);
   assign nx_offset = nx_accept ? off_w : '0;
   assign nx_fill   = req_valid && !nx_accept && !req_write;
   assign nx_wgo    = nx_accept && req_write;

   if (PIPE_OUT) begin : g_pipe
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid     <= 1'b0;
            out_accept    <= 1'b0;
            out_offset    <= '0;
            out_fill_ones <= 1'b0;
            out_wr_go     <= 1'b0;
         end else begin
            out_valid     <= req_valid;
            out_accept    <= nx_accept;
            out_offset    <= nx_offset;
            out_fill_ones <= nx_fill;
            out_wr_go     <= nx_wgo;
         end
      end

      // R9: result strobe follows request strobe by one cycle
      a_r9_valid_lat: assert property (@(posedge clk) disable iff (!rst_n)
         req_valid |=> out_valid);
      a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         !req_valid |=> !out_valid);
      // R5: a disabled window never accepts
      a_r5_off_rejects: assert property (@(posedge clk) disable iff (!rst_n)
         !en_w |=> !out_accept);
      // R2: root bus with nonzero devfn is rejected
      a_r2_root_fn0: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_bus == root_bus && req_devfn != '0) |=> !out_accept);
      // R3: other buses are rejected while the link is down
      a_r3_link_down: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_bus != root_bus && !link_up) |=> !out_accept);
      // R4: bus above the last bus is rejected
      a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_bus > BUS_W'(size_w)) |=> !out_accept);
      // R8: rejected accesses neither write nor carry an offset
      a_r8_drop_write: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && !out_accept) |-> (!out_wr_go && out_offset == '0));
      a_r8_fill_only_reject: assert property (@(posedge clk) disable iff (!rst_n)
         out_fill_ones |-> (out_valid && !out_accept));
   end else begin : g_comb
      assign out_valid     = req_valid;
      assign out_accept    = nx_accept;
      assign out_offset    = nx_offset;
      assign out_fill_ones = nx_fill;
      assign out_wr_go     = nx_wgo;
   end

endmodule

// File: tb/ecam_cfg_decode_tb_top.sv
module ecam_cfg_decode_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr_en = 1'b0;
   logic [31:0] ctl_wr_data = '0;
   logic [31:0] ctl_rd_data;
   logic [31:0] cap_rd_data;
   logic [7:0]  root_bus = '0;
   logic        link_up = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_bus = '0;
   logic [7:0]  req_devfn = '0;
   logic [11:0] req_reg = '0;
   logic        out_valid;
   logic        out_accept;
   logic [27:0] out_offset;
   logic        out_fill_ones;
   logic        out_wr_go;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   // model state, kept from the requirements
   bit          m_en = 1'b0;
   logic [4:0]  m_size = 5'd12;

   always #2 clk = ~clk;

   ecam_cfg_decode dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
      .ctl_rd_data(ctl_rd_data), .cap_rd_data(cap_rd_data), .root_bus(root_bus),
      .link_up(link_up), .req_valid(req_valid), .req_write(req_write),
      .req_bus(req_bus), .req_devfn(req_devfn), .req_reg(req_reg),
      .out_valid(out_valid), .out_accept(out_accept), .out_offset(out_offset),
      .out_fill_ones(out_fill_ones), .out_wr_go(out_wr_go)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s: got %h expected %h", rq, act, exp);
      end
   endtask

   task automatic ctl_write(input logic [31:0] v);
      @(negedge clk);
      ctl_wr_en = 1'b1; ctl_wr_data = v;
      @(negedge clk);
      ctl_wr_en = 1'b0;
      m_en = v[0]; m_size = v[20:16];
   endtask

   // Drive one request, then check every output one cycle later
   task automatic send(input string rq, input logic [7:0] b, input logic [7:0] df,
                       input logic [11:0] rg, input bit wr);
      bit acc;
      logic [27:0] off;
      acc = m_en && (b <= {3'b0, m_size}) && ((b == root_bus) ? (df == 0) : link_up);
      off = acc ? ((28'(b) << 20) | (28'(df) << 12)) + 28'(rg) : 28'd0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_bus = b; req_devfn = df; req_reg = rg;
      @(negedge clk);
      req_valid = 1'b0;
      chk({rq, " valid"}, 32'(out_valid), 32'd1);
      chk({rq, " accept"}, 32'(out_accept), 32'(acc));
      chk({rq, " offset"}, 32'(out_offset), 32'(off));
      chk({rq, " fill"}, 32'(out_fill_ones), 32'(!acc && !wr));
      chk({rq, " wr_go"}, 32'(out_wr_go), 32'(acc && wr));
   endtask

   task automatic t_reset;
      chk("R6 reset ctl", ctl_rd_data, 32'h000C_0000);
      chk("R7 cap", cap_rd_data, 32'h0000_0001);
      chk("R9 reset valid", 32'(out_valid), 32'd0);
   endtask

   task automatic t_ctl;
      ctl_write(32'hFFFF_FFFF);
      chk("R6 readback", ctl_rd_data, 32'h001F_0001);
      ctl_write(32'h0004_0001);
      chk("R6 readback size4", ctl_rd_data, 32'h0004_0001);
   endtask

   task automatic t_offset;
      ctl_write(32'h001F_0001);
      link_up = 1'b1; root_bus = 8'd0;
      send("R1 offset a", 8'd1, 8'h2B, 12'h3FC, 1'b0);
      chk("R1 value a", 32'(out_offset), 32'h012B_3FC);
      send("R1 offset b", 8'd30, 8'hFF, 12'h001, 1'b0);
      chk("R1 value b", 32'(out_offset), 32'h01EF_F001);
   endtask

   task automatic t_root;
      link_up = 1'b0; root_bus = 8'd3;
      send("R2 root fn1", 8'd3, 8'd1, 12'h010, 1'b0);
      chk("R2 rejected", 32'(out_accept), 32'd0);
      send("R2 root fn0 link down", 8'd3, 8'd0, 12'h010, 1'b0);
      chk("R2 accepted", 32'(out_accept), 32'd1);
   endtask

   task automatic t_link;
      root_bus = 8'd0;
      link_up = 1'b0;
      send("R3 link down", 8'd2, 8'd0, 12'h000, 1'b0);
      chk("R3 rejected", 32'(out_accept), 32'd0);
      link_up = 1'b1;
      send("R3 link up", 8'd2, 8'd0, 12'h000, 1'b0);
      chk("R3 accepted", 32'(out_accept), 32'd1);
   endtask

   task automatic t_range;
      ctl_write(32'h0004_0001);
      link_up = 1'b1; root_bus = 8'd0;
      send("R4 at last", 8'd4, 8'd8, 12'h004, 1'b0);
      chk("R4 last ok", 32'(out_accept), 32'd1);
      send("R4 above last", 8'd5, 8'd8, 12'h004, 1'b0);
      chk("R4 above rejected", 32'(out_accept), 32'd0);
   endtask

   task automatic t_disable;
      ctl_write(32'h001F_0000);
      send("R5 off root", 8'd0, 8'd0, 12'h000, 1'b0);
      chk("R5 off rejected", 32'(out_accept), 32'd0);
      send("R5 off write", 8'd1, 8'd0, 12'h000, 1'b1);
      chk("R5 off no write", 32'(out_wr_go), 32'd0);
   endtask

   task automatic t_rw;
      ctl_write(32'h001F_0001);
      link_up = 1'b0; root_bus = 8'd0;
      send("R8 rej read", 8'd6, 8'd0, 12'h020, 1'b0);
      chk("R8 fill ones", 32'(out_fill_ones), 32'd1);
      send("R8 rej write", 8'd6, 8'd0, 12'h020, 1'b1);
      chk("R8 write dropped", 32'(out_wr_go), 32'd0);
      link_up = 1'b1;
      send("R8 acc write", 8'd6, 8'd0, 12'h020, 1'b1);
      chk("R8 write go", 32'(out_wr_go), 32'd1);
   endtask

   task automatic t_idle;
      @(negedge clk);
      @(negedge clk);
      chk("R9 idle", 32'(out_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctl();
      t_offset();
      t_root();
      t_link();
      t_range();
      t_disable();
      t_rw();
      t_idle();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nvec++;
         nbad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

endmodule